// File: doc/BRIEF.md
# Relocatable Register Window Decoder

This block owns the base register that positions an 8-kbyte window holding every internal module register. The window can sit only on an 8-kbyte boundary. A bus master reads or writes the base register through a special function-code space, and there only at one fixed address. Every other access is compared against the stored base. When it falls inside the window, the block raises an internal-select line and passes on the 13-bit offset, which the module register files decode.

After reset the window is switched off. A valid flag records the first write to the base register. Until that write, no ordinary access is claimed, so the register block cannot mask external memory before software has placed it. Read data and the select outputs are combinational. Only the base register and the valid flag hold state.

Top module: `base_window_decode`

## Requirements
- R1: After reset the valid flag is clear. Reading the base register then returns 0, and internal-select stays low for every address and function code.
- R2: A write with `acc_valid`=1, `wr`=1, `fc`=7 and `addr`=0x0003FF00 stores `wdata[31:13]` as the base and sets the valid flag at the next rising clock edge.
- R3: A read of the base register (`fc`=7, `addr`=0x0003FF00, `wr`=0) returns the base in bits 31..13, zeros in bits 12..1 and the valid flag in bit 0, whatever low bits were written.
- R4: A write to 0x0003FF00 with any function code other than 7 leaves the base register and the valid flag unchanged.
- R5: A write with function code 7 at any address other than 0x0003FF00 leaves the base register and the valid flag unchanged.
- R6: `int_sel` is 1 when `acc_valid` is 1, the valid flag is set, `fc` is not 7 and `addr[31:13]` equals the stored base. Otherwise it is 0.
- R7: An access with function code 7 never asserts `int_sel`, even when its address lies inside the window.
- R8: `offset` equals `addr[12:0]` while `int_sel` is 1 and is 0 otherwise.
- R9: `rdata` is 0 for every access that is not a read of the base register.
- R10: With `acc_valid` at 0, neither `int_sel` nor `rdata` responds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is present on the bus this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| fc | input | 3 | Function code; 7 selects CPU space |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data for the base register |
| rdata | output | 32 | Base register read data |
| int_sel | output | 1 | Access falls inside the internal register window |
| offset | output | 13 | Byte offset within the window |

## Verification
The hardest case to reach from the ports is a window that covers the base register's own fixed address. The same address must then be claimed by the window in ordinary space while it still reaches the base register in CPU space. The bench relocates the base to 0x0003E000. It then probes 0x0003FF00 under both function codes and checks that the register still reads back correctly. The window's edges, the neighbouring windows and a top-bit mismatch are covered by a table of probes.

// File: rtl/base_window_decode.sv
module base_window_decode #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 13,
  parameter int FC_W     = 3,
  parameter logic [FC_W-1:0]   CPU_FC   = 3'd7,
  parameter logic [ADDR_W-1:0] REG_ADDR = 32'h0003_FF00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                wr,
  input  logic [FC_W-1:0]     fc,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [ADDR_W-1:0]   wdata,
  output logic [ADDR_W-1:0]   rdata,
  output logic                int_sel,
  output logic [WIN_BITS-1:0] offset
);
  localparam int TAG_W = ADDR_W - WIN_BITS;

  logic [TAG_W-1:0] base_q;
  logic             valid_q;

  wire cpu_space = (fc == CPU_FC);
  wire reg_hit   = acc_valid && cpu_space && (addr == REG_ADDR);
  wire reg_write = reg_hit && wr;
  wire reg_read  = reg_hit && !wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      valid_q <= 1'b0;
    end else if (reg_write) begin
      base_q  <= wdata[ADDR_W-1:WIN_BITS];
      valid_q <= 1'b1;
    end
  end

  assign int_sel = acc_valid && valid_q && !cpu_space &&
                   (addr[ADDR_W-1:WIN_BITS] == base_q);
  assign offset  = int_sel ? addr[WIN_BITS-1:0] : '0;
  assign rdata   = reg_read ? {base_q, {(WIN_BITS-1){1'b0}}, valid_q} : '0;

  // R2
  base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_write |=> (valid_q && base_q == $past(wdata[ADDR_W-1:WIN_BITS])));

  // R4 R5
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_write |=> ($stable(base_q) && $stable(valid_q)));

  // R1
  valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(reg_write));

  // R7
  cpu_space_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_space |-> !int_sel);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!int_sel && rdata == '0));

  // R9
  rdata_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != '0) |-> !int_sel);
endmodule

// File: tb/sim_base_window_decode.sv
module sim_base_window_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, wr = 1'b0;
  logic [2:0]  fc = 3'd0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata;
  logic        int_sel;
  logic [12:0] offset;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [31:0] REG = 32'h0003_FF00;

  always #5 clk = ~clk;

  base_window_decode u0 (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .wr(wr),
    .fc(fc), .addr(addr), .wdata(wdata), .rdata(rdata), .int_sel(int_sel), .offset(offset));

  // probe vector: {fc[2:0], addr[31:0], exp_sel, exp_off[12:0]}, base = 0x12346000
  localparam logic [48:0] TBL [8] = '{
    {3'd5, 32'h1234_6000, 1'b1, 13'h0000},
    {3'd5, 32'h1234_7FFF, 1'b1, 13'h1FFF},
    {3'd1, 32'h1234_6ABC, 1'b1, 13'h0ABC},
    {3'd2, 32'h1234_8000, 1'b0, 13'h0000},
    {3'd6, 32'h1234_5FFF, 1'b0, 13'h0000},
    {3'd7, 32'h1234_6010, 1'b0, 13'h0000},
    {3'd5, 32'h9234_6000, 1'b0, 13'h0000},
    {3'd2, 32'h1234_754A, 1'b1, 13'h154A}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(logic v, logic w, logic [2:0] f, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    acc_valid = v; wr = w; fc = f; addr = a; wdata = d;
    #2;
  endtask

  task automatic write_cycle(logic [2:0] f, logic [31:0] a, logic [31:0] d);
    put(1'b1, 1'b1, f, a, d);
    @(posedge clk);
    put(1'b0, 1'b0, 3'd0, '0, '0);
  endtask

  task automatic read_base(string tag, logic [31:0] exp);
    put(1'b1, 1'b0, 3'd7, REG, '0);
    check(tag, rdata, exp);
    check({tag, " sel"}, {31'd0, int_sel}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    read_base("R1 base after reset", 32'h0);
    put(1'b1, 1'b0, 3'd5, 32'h0000_0010, '0);
    check("R1 no window before write", {31'd0, int_sel}, 32'd0);

    write_cycle(3'd7, REG, 32'h1234_6FFF);
    read_base("R2 R3 base readback", 32'h1234_6001);

    for (int i = 0; i < 8; i++) begin
      put(1'b1, 1'b0, TBL[i][48:46], TBL[i][45:14], '0);
      check($sformatf("R6 R7 sel vec%0d", i), {31'd0, int_sel}, {31'd0, TBL[i][13]});
      check($sformatf("R8 offset vec%0d", i), {19'd0, offset}, {19'd0, TBL[i][12:0]});
      check($sformatf("R9 rdata vec%0d", i), rdata, 32'h0);
    end

    write_cycle(3'd5, REG, 32'hDEAD_0000);
    read_base("R4 other fc at reg addr", 32'h1234_6001);
    write_cycle(3'd7, REG + 32'h4, 32'hBEEF_0000);
    read_base("R5 cpu space other addr", 32'h1234_6001);
    put(1'b1, 1'b0, 3'd7, REG + 32'h4, '0);
    check("R9 cpu read elsewhere", rdata, 32'h0);

    put(1'b0, 1'b0, 3'd5, 32'h1234_6100, '0);
    check("R10 idle sel", {31'd0, int_sel}, 32'd0);
    check("R10 idle offset", {19'd0, offset}, 32'd0);
    put(1'b0, 1'b0, 3'd7, REG, '0);
    check("R10 idle rdata", rdata, 32'h0);

    write_cycle(3'd7, REG, 32'h0003_E000);
    put(1'b1, 1'b0, 3'd5, REG, '0);
    check("R6 window over reg addr sel", {31'd0, int_sel}, 32'd1);
    check("R8 window over reg addr offset", {19'd0, offset}, 32'h1F00);
    read_base("R7 R3 reg still reachable", 32'h0003_E001);
    put(1'b1, 1'b0, 3'd5, 32'h1234_6000, '0);
    check("R6 old window released", {31'd0, int_sel}, 32'd0);

    put(1'b0, 1'b0, 3'd0, '0, '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule